// File: doc/BRIEF.md
# Board Interrupt Collector with Control Registers

This block gathers sixteen level-sensitive interrupt lines from board peripherals and presents them to a processor as a single interrupt request. Each line is sampled on the clock. A line that changes level updates a raw-level register. If its enable bit is set, the change also overwrites a status register with a one-hot code that names that line, and the request output is set to that line's new level. A line whose enable bit is clear only updates the raw-level copy. Line 3 is reserved for the network controller.

Software reaches the block through a simple word bus with an address, separate read and write strobes, write data and registered read data. The enable and status registers only accept the bit positions in the constant 0x000FEEFF. Ten plain storage words hold board control settings: LED data and control, switches, miscellaneous write and read words, and two card-slot words. An access to an undecoded offset raises an error strobe for one cycle.

Top module: `brd_irq_hub`

## Requirements
- R1: While reset is high, and in the cycle after reset, the request output, error strobe and read data are zero, and every register reads back as zero.
- R2: The raw-level register at offset 0xC4 holds the level of each of the 16 lines (bit i for line i) as sampled at the last clock edge. Bits go to 1 on a rise and to 0 on a fall. Bus writes to 0xC4 are ignored.
- R3: The enable register at offset 0xC0 stores write data ANDed with 0x000FEEFF.
- R4: The status register at offset 0xD0 stores bus write data ANDed with 0x000FEEFF.
- R5: When an enabled line changes level at a clock edge, at that same edge the status register becomes one-hot with only bit i set, and the request output takes the line's new level.
- R6: A change on a line whose enable bit is 0 leaves the status register and the request output unchanged.
- R7: If several enabled lines change at the same edge, the highest-numbered one sets the status register and the request output.
- R8: The plain words at offsets 0x10, 0x14, 0x40, 0x60, 0x80, 0x84, 0x88, 0x90, 0xE0 and 0xE4 store and return all 32 written bits.
- R9: A read or write at any other offset, including an offset that is not a multiple of 4, sets the error strobe for exactly the next cycle. Such a read returns zero and such a write changes no register.
- R10: Read data is registered. It shows the addressed word one cycle after the read strobe and is zero in every cycle that does not follow a read.
- R11: If an enabled line changes in the same cycle as a bus write to the status register, the line event wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | 16 | Interrupt lines, bit i is line i |
| bus_addr | input | 8 | Byte offset within the block |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_err | output | 1 | One-cycle strobe for an undecoded offset |
| parent_irq | output | 1 | Interrupt request toward the processor |

## Verification
The checker keeps its own copy of the previous line levels. On every cycle it checks four things:
- A change confined to disabled lines leaves the request and status unchanged.
- An enabled change always leaves the status one-hot.
- The enable register never holds a bit outside 0x000FEEFF.
- An undecoded read returns zero with the error strobe, and the strobe stays low after an idle cycle.

Only the bench scenarios can show the rest:
- the exact index chosen when several lines change together;
- the request following the most recent line rather than the OR of all lines;
- the event winning over a status write in the same cycle;
- the full contents of each plain word.

// File: rtl/brd_irq_pkg.sv
package brd_irq_pkg;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;
    localparam int NSRC   = 16;
    localparam int NPLAIN = 10;
    localparam logic [DATA_W-1:0] KEEP_MASK = 32'h000F_EEFF;

    typedef enum logic [2:0] {
        K_NONE,
        K_PLAIN,
        K_RAW,
        K_MASK,
        K_STAT
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e  kind;
        logic [3:0] slot;
    } reg_sel_t;

    function automatic reg_sel_t decode(input logic [ADDR_W-1:0] a);
        reg_sel_t s;
        s.kind = K_PLAIN;
        s.slot = 4'd0;
        case (a)
            8'h10: s.slot = 4'd0;
            8'h14: s.slot = 4'd1;
            8'h40: s.slot = 4'd2;
            8'h60: s.slot = 4'd3;
            8'h80: s.slot = 4'd4;
            8'h84: s.slot = 4'd5;
            8'h88: s.slot = 4'd6;
            8'h90: s.slot = 4'd7;
            8'hE0: s.slot = 4'd8;
            8'hE4: s.slot = 4'd9;
            8'hC0: s.kind = K_MASK;
            8'hC4: s.kind = K_RAW;
            8'hD0: s.kind = K_STAT;
            default: s.kind = K_NONE;
        endcase
        return s;
    endfunction
endpackage

// File: rtl/brd_irq_detect.sv
module brd_irq_detect
    import brd_irq_pkg::*;
#(
    parameter int N  = NSRC,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  src_i,
    input  logic [N-1:0]  en_i,
    output logic [N-1:0]  raw_o,
    output logic          hit_o,
    output logic [IW-1:0] idx_o,
    output logic          lvl_o
);
    logic [N-1:0] raw_q;
    logic [N-1:0] chg;

    always_ff @(posedge clk) begin
        if (rst) raw_q <= '0;
        else     raw_q <= src_i;
    end

    assign chg = (src_i ^ raw_q) & en_i;

    // ascending scan: the last hit, i.e. the highest index, wins
    always_comb begin
        hit_o = 1'b0;
        idx_o = '0;
        for (int i = 0; i < N; i++) begin
            if (chg[i]) begin
                hit_o = 1'b1;
                idx_o = IW'(i);
            end
        end
    end

    assign lvl_o = src_i[idx_o];
    assign raw_o = raw_q;
endmodule

// File: rtl/brd_irq_regs.sv
module brd_irq_regs
    import brd_irq_pkg::*;
#(
    parameter int N  = NSRC,
    parameter int DW = DATA_W,
    parameter logic [DW-1:0] WMASK = KEEP_MASK,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    input  logic [DW-1:0]     wdata,
    input  logic [N-1:0]      raw_i,
    input  logic              hit_i,
    input  logic [IW-1:0]     idx_i,
    output logic [DW-1:0]     rdata,
    output logic              err,
    output logic [DW-1:0]     mask_o,
    output logic [DW-1:0]     stat_o
);
    reg_sel_t      sel;
    logic [DW-1:0] plain_q [NPLAIN];
    logic [DW-1:0] mask_q, stat_q, rd_mux;

    assign sel = decode(addr);

    for (genvar g = 0; g < NPLAIN; g++) begin : g_plain
        always_ff @(posedge clk) begin
            if (rst) plain_q[g] <= '0;
            else if (wr && sel.kind == K_PLAIN && sel.slot == 4'(g))
                plain_q[g] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) mask_q <= '0;
        else if (wr && sel.kind == K_MASK) mask_q <= wdata & WMASK;
    end

    // line event takes priority over a software write
    always_ff @(posedge clk) begin
        if (rst)                           stat_q <= '0;
        else if (hit_i)                    stat_q <= DW'(1) << idx_i;
        else if (wr && sel.kind == K_STAT) stat_q <= wdata & WMASK;
    end

    always_comb begin
        case (sel.kind)
            K_PLAIN: rd_mux = plain_q[sel.slot];
            K_RAW:   rd_mux = DW'(raw_i);
            K_MASK:  rd_mux = mask_q;
            K_STAT:  rd_mux = stat_q;
            default: rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
            err   <= 1'b0;
        end else begin
            rdata <= rd ? rd_mux : '0;
            err   <= (rd || wr) && sel.kind == K_NONE;
        end
    end

    assign mask_o = mask_q;
    assign stat_o = stat_q;
endmodule

// File: rtl/brd_irq_hub.sv
module brd_irq_hub
    import brd_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [NSRC-1:0]   src_i,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_err,
    output logic              parent_irq
);
    localparam int IW = (NSRC > 1) ? $clog2(NSRC) : 1;

    logic [NSRC-1:0]   raw_lvl;
    logic              ev_hit, ev_lvl;
    logic [IW-1:0]     ev_idx;
    logic [DATA_W-1:0] mask_q, status_q;
    logic              parent_q;

    brd_irq_detect #(.N(NSRC)) u_det (
        .clk   (clk),
        .rst   (rst),
        .src_i (src_i),
        .en_i  (mask_q[NSRC-1:0]),
        .raw_o (raw_lvl),
        .hit_o (ev_hit),
        .idx_o (ev_idx),
        .lvl_o (ev_lvl)
    );

    brd_irq_regs #(.N(NSRC), .DW(DATA_W), .WMASK(KEEP_MASK)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .addr   (bus_addr),
        .wr     (bus_wr),
        .rd     (bus_rd),
        .wdata  (bus_wdata),
        .raw_i  (raw_lvl),
        .hit_i  (ev_hit),
        .idx_i  (ev_idx),
        .rdata  (bus_rdata),
        .err    (bus_err),
        .mask_o (mask_q),
        .stat_o (status_q)
    );

    always_ff @(posedge clk) begin
        if (rst)         parent_q <= 1'b0;
        else if (ev_hit) parent_q <= ev_lvl;
    end

    assign parent_irq = parent_q;
endmodule

// File: rtl/brd_irq_hub_chk.sv
module brd_irq_hub_chk
    import brd_irq_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [NSRC-1:0]   src_i,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              bus_err,
    input logic              parent_irq,
    input logic [DATA_W-1:0] mask_q,
    input logic [DATA_W-1:0] status_q
);
    logic [NSRC-1:0] prev_q;
    logic [NSRC-1:0] en_chg;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= src_i;
    end

    assign en_chg = (src_i ^ prev_q) & mask_q[NSRC-1:0];

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (parent_irq == 1'b0 && bus_err == 1'b0 && bus_rdata == '0));

    assert_mask_filtered_R3: assert property (@(posedge clk) disable iff (rst)
        (mask_q & ~KEEP_MASK) == '0);

    assert_onehot_event_R5: assert property (@(posedge clk) disable iff (rst)
        en_chg != '0 |=> $countones(status_q) == 1);

    assert_masked_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        (en_chg == '0 && !(bus_wr && decode(bus_addr).kind == K_STAT))
        |=> ($stable(parent_irq) && $stable(status_q)));

    assert_bad_read_zero_R9: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && decode(bus_addr).kind == K_NONE) |=> (bus_err && bus_rdata == '0));

    assert_idle_no_err_R9: assert property (@(posedge clk) disable iff (rst)
        !(bus_rd || bus_wr) |=> !bus_err);

    assert_idle_rdata_zero_R10: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> bus_rdata == '0);
endmodule

bind brd_irq_hub brd_irq_hub_chk u_chk (.*);

// File: tb/brd_irq_hub_tb.sv
module brd_irq_hub_tb;
    import brd_irq_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [NSRC-1:0]   src_i = '0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_wr = 1'b0;
    logic              bus_rd = 1'b0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic              bus_err;
    logic              parent_irq;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    brd_irq_hub u_dut (
        .clk        (clk),
        .rst        (rst),
        .src_i      (src_i),
        .bus_addr   (bus_addr),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .bus_err    (bus_err),
        .parent_irq (parent_irq)
    );

    localparam int NV = 13;
    localparam logic [7:0]  V_ADDR [NV] = '{8'h10, 8'h14, 8'h40, 8'h60, 8'h80, 8'h84,
        8'h88, 8'h90, 8'hE0, 8'hE4, 8'hC0, 8'hD0, 8'hC4};
    localparam logic [31:0] V_WDAT [NV] = '{32'hDEADBEEF, 32'h12345678, 32'hA5A5A5A5,
        32'h0000FFFF, 32'hFFFF0000, 32'h80000001, 32'h13579BDF, 32'h2468ACE0,
        32'hCAFEF00D, 32'h0F0F0F0F, 32'hFFFFFFFF, 32'h12345678, 32'h0000FFFF};
    localparam logic [31:0] V_EXP  [NV] = '{32'hDEADBEEF, 32'h12345678, 32'hA5A5A5A5,
        32'h0000FFFF, 32'hFFFF0000, 32'h80000001, 32'h13579BDF, 32'h2468ACE0,
        32'hCAFEF00D, 32'h0F0F0F0F, 32'h000FEEFF, 32'h00044678, 32'h00000000};

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic drive_src(input logic [15:0] v);
        @(negedge clk);
        src_i = v;
        @(negedge clk);
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        chk("R1 parent in reset", 32'(parent_irq), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 parent after reset", 32'(parent_irq), 0);
        chk("R1 err after reset", 32'(bus_err), 0);
        chk("R1 rdata after reset", bus_rdata, 0);
        rd(8'hC0, d); chk("R1 mask reset", d, 0);
        rd(8'hD0, d); chk("R1 status reset", d, 0);
        rd(8'h10, d); chk("R1 led reset", d, 0);

        // R8 R3 R4 R2 table walk
        for (int i = 0; i < NV; i++) begin
            wr(V_ADDR[i], V_WDAT[i]);
            rd(V_ADDR[i], d);
            chk("R8/R3/R4/R2 table", d, V_EXP[i]);
        end

        // R10 rdata returns to zero
        @(negedge clk);
        chk("R10 idle rdata", bus_rdata, 0);

        // R6 masked line only touches raw level
        wr(8'hC0, 32'h0); wr(8'hD0, 32'h0);
        drive_src(16'h0008);
        chk("R6 parent unchanged", 32'(parent_irq), 0);
        rd(8'hD0, d); chk("R6 status unchanged", d, 0);
        rd(8'hC4, d); chk("R2 raw level rise", d, 32'h8);
        wr(8'hC4, 32'hFFFF);
        rd(8'hC4, d); chk("R2 raw write ignored", d, 32'h8);

        // R5 enabled line 3
        wr(8'hC0, 32'h8);
        drive_src(16'h0000);
        chk("R5 fall parent", 32'(parent_irq), 0);
        rd(8'hD0, d); chk("R5 fall status", d, 32'h8);
        rd(8'hC4, d); chk("R2 raw level fall", d, 0);
        wr(8'hD0, 32'h0);
        drive_src(16'h0008);
        chk("R5 rise parent", 32'(parent_irq), 1);
        rd(8'hD0, d); chk("R5 rise status", d, 32'h8);

        // R6 masked line 5 while parent high
        drive_src(16'h0028);
        chk("R6 masked toggle parent", 32'(parent_irq), 1);
        rd(8'hD0, d); chk("R6 masked toggle status", d, 32'h8);
        drive_src(16'h0000);
        chk("R5 line3 fall parent", 32'(parent_irq), 0);

        // R7 simultaneous lines 0 and 15
        wr(8'hC0, 32'h8009); wr(8'hD0, 32'h0);
        drive_src(16'h8001);
        chk("R7 parent", 32'(parent_irq), 1);
        rd(8'hD0, d); chk("R7 status highest", d, 32'h8000);
        drive_src(16'h8000);
        chk("R5 latest line parent", 32'(parent_irq), 0);
        rd(8'hD0, d); chk("R5 latest line status", d, 32'h1);

        // R11 event beats status write
        @(negedge clk);
        bus_addr = 8'hD0; bus_wdata = 32'h4; bus_wr = 1'b1; src_i = 16'h0000;
        @(negedge clk);
        bus_wr = 1'b0;
        chk("R11 parent", 32'(parent_irq), 0);
        rd(8'hD0, d); chk("R11 status", d, 32'h8000);

        // R9 undecoded offsets
        @(negedge clk);
        bus_addr = 8'h20; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        chk("R9 bad read err", 32'(bus_err), 1);
        chk("R9 bad read data", bus_rdata, 0);
        @(negedge clk);
        chk("R9 err one cycle", 32'(bus_err), 0);
        @(negedge clk);
        bus_addr = 8'h12; bus_wdata = 32'h1234; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        chk("R9 bad write err", 32'(bus_err), 1);
        rd(8'h10, d); chk("R9 bad write no effect", d, 32'hDEADBEEF);
        rd(8'h14, d); chk("R9 bad write neighbour", d, 32'h12345678);

        // R1 reset again clears everything
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        rd(8'h40, d); chk("R1 plain cleared", d, 0);
        rd(8'hC0, d); chk("R1 mask cleared", d, 0);

        summary();
    end
endmodule